// File: doc/BRIEF.md
# Backplane Arbiter with Local Requester

This block lets one board act both as the arbiter for a shared backplane and as the requester on behalf of its own local master. Other boards raise requests on two prioritised backplane request lines. The arbiter answers each one on a matching acknowledge line. The local master has its own request, which the block places on one of those two levels. Because the local request enters the same arbitration as every other board, the local master wins or waits on equal terms.

Three static straps set how the local side behaves:
- a level select picks which request line the local master uses;
- a parking strap makes this board the default owner whenever nobody else asks;
- a hold strap keeps ownership after the local cycles finish, until another board raises a request.

A lock input keeps the bus with the local master across several cycles, so that a read-modify-write sequence cannot be split.

Ownership passes only when the current owner has withdrawn its request and no transfer is in progress. Every handover includes at least one clock with no acknowledge asserted. Backplane inputs are resynchronised before they are used.

Top module: `arbreq_top`

## Requirements
- R1: While reset is held and directly after it, `bp_ack_out`, `bp_req_out` and `loc_grant` are all zero.
- R2: `bp_req_out` is zero or has exactly one bit set. That bit is the one at index `cfg_level`, and it rises on the first clock edge after `loc_want` rises.
- R3: `loc_grant` is high only while the local request is out and `bp_ack_out[cfg_level]` is high.
- R4: `bp_ack_out` has at most one bit set. When requests on both levels are pending at a free bus, the acknowledge goes to level 1 (bit 1).
- R5: An acknowledge holds while its level is still requested or while any transfer is in progress (`loc_busy` or the synchronised `bp_busy_in`).
- R6: When ownership moves from one level to another, at least one clock passes with `bp_ack_out` all zero.
- R7: With `cfg_park` high, the local request stays up while no backplane request is seen, and it drops once one appears (unless the local master wants the bus, is busy or holds lock).
- R8: With `cfg_hold` high, a local request that is already out stays out after `loc_want` falls, until a backplane request is seen.
- R9: With both straps low, the local request drops on the first edge at which `loc_want`, `loc_lock` and `loc_busy` are all low.
- R10: While `loc_lock` is high and `loc_grant` is high, `loc_grant` stays high on the next clock, even with other requests pending.
- R11: A backplane request goes through a two-flop synchroniser. At a free bus, its acknowledge appears after the third rising edge that follows the change on `bp_req_in`, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| cfg_level | input | 1 | Request level used by the local master (0 or 1) |
| cfg_park | input | 1 | Strap: this board is the default owner |
| cfg_hold | input | 1 | Strap: keep ownership until another board requests |
| loc_want | input | 1 | The local master has cycles pending |
| loc_busy | input | 1 | A local transfer is in progress |
| loc_lock | input | 1 | Keep the bus for an indivisible sequence |
| loc_grant | output | 1 | The local master owns the bus |
| bp_req_in | input | 2 | Backplane request lines from other boards, bit 1 highest |
| bp_busy_in | input | 1 | A transfer by another board is in progress |
| bp_req_out | output | 2 | Local request placed on the selected level |
| bp_ack_out | output | 2 | Acknowledge lines, one per level |

## Verification
The assertions take the three straps as static: they are set while reset is held and left alone afterwards. The local inputs are taken as already synchronous to `clk`. The backplane inputs may change on any cycle. The stimulus changes straps only inside reset phases. It drives every input half a period away from the active edge, and it keeps lock pulses rare, so that handovers still occur often during the random phase.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NLVL = 2;
  localparam int LW   = (NLVL > 1) ? $clog2(NLVL) : 1;

  typedef enum logic {ARB_IDLE, ARB_OWNED} arb_state_e;

  // highest pending level wins
  function automatic logic [LW-1:0] top_level(input logic [NLVL-1:0] r);
    logic [LW-1:0] res;
    res = '0;
    for (int i = 0; i < NLVL; i++)
      if (r[i]) res = LW'(i);
    return res;
  endfunction

  function automatic logic [NLVL-1:0] level_bit(input logic [LW-1:0] l);
    return NLVL'(1) << l;
  endfunction
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/arb_requester.sv
module arb_requester (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_park,
  input  logic cfg_hold,
  input  logic want,
  input  logic busy,
  input  logic lock,
  input  logic others_req,
  output logic req_q
);
  logic ev_park, ev_keep, ev_finish, req_d;

  assign ev_park   = cfg_park & ~others_req;
  assign ev_keep   = cfg_hold & req_q & ~others_req;
  assign ev_finish = req_q & busy;
  assign req_d     = want | lock | ev_finish | ev_park | ev_keep;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hold && req_q && !others_req) |=> req_q);

  assert_plain_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_park && !cfg_hold && !want && !lock && !busy) |=> !req_q);

  assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_park && !others_req) |=> req_q);
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_all,
  input  logic            busy_all,
  output logic [NLVL-1:0] ack
);
  arb_state_e    state;
  logic [LW-1:0] owner;
  logic          owner_done, any_req;

  assign owner_done = !req_all[owner] && !busy_all;
  assign any_req    = |req_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ARB_IDLE;
      owner <= '0;
    end else begin
      case (state)
        ARB_IDLE: if (any_req) begin
          state <= ARB_OWNED;
          owner <= top_level(req_all);
        end
        ARB_OWNED: if (owner_done) state <= ARB_IDLE;
        default: state <= ARB_IDLE;
      endcase
    end
  end

  assign ack = (state == ARB_OWNED) ? level_bit(owner) : '0;

  assert_one_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_high_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_IDLE && req_all[NLVL-1]) |=> ack[NLVL-1]);

  assert_ack_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack) && ((|(req_all & ack)) || busy_all)) |=> (ack == $past(ack)));

  assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack) && (|$past(ack))) |-> (ack == $past(ack)));
endmodule

// File: rtl/arbreq_top.sv
module arbreq_top
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   cfg_level,
  input  logic            cfg_park,
  input  logic            cfg_hold,
  input  logic            loc_want,
  input  logic            loc_busy,
  input  logic            loc_lock,
  output logic            loc_grant,
  input  logic [NLVL-1:0] bp_req_in,
  input  logic            bp_busy_in,
  output logic [NLVL-1:0] bp_req_out,
  output logic [NLVL-1:0] bp_ack_out
);
  logic [NLVL-1:0] req_sync;
  logic            busy_sync, loc_req_q, others_req, busy_all;
  logic [NLVL-1:0] req_all;

  arb_sync #(.W(NLVL + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bp_busy_in, bp_req_in}), .q({busy_sync, req_sync})
  );

  assign others_req = |req_sync;

  arb_requester u_req (
    .clk(clk), .rst_n(rst_n), .cfg_park(cfg_park), .cfg_hold(cfg_hold),
    .want(loc_want), .busy(loc_busy), .lock(loc_lock),
    .others_req(others_req), .req_q(loc_req_q)
  );

  assign bp_req_out = loc_req_q ? level_bit(cfg_level) : '0;
  assign req_all    = req_sync | bp_req_out;
  assign busy_all   = loc_busy | busy_sync;

  arb_grant_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_all(req_all),
    .busy_all(busy_all), .ack(bp_ack_out)
  );

  assign loc_grant = loc_req_q & bp_ack_out[cfg_level];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (bp_ack_out == '0 && bp_req_out == '0));

  assert_req_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bp_req_out));

  assert_grant_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_grant |-> (bp_ack_out[cfg_level] && bp_req_out != '0));

  assert_lock_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_lock && loc_grant) |=> loc_grant);
endmodule

// File: tb/arbreq_top_tb_top.sv
module arbreq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_level = 1'b0, cfg_park = 1'b0, cfg_hold = 1'b0;
  logic       loc_want = 1'b0, loc_busy = 1'b0, loc_lock = 1'b0;
  logic       loc_grant;
  logic [1:0] bp_req_in = 2'b00;
  logic       bp_busy_in = 1'b0;
  logic [1:0] bp_req_out, bp_ack_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  arbreq_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_park(cfg_park),
    .cfg_hold(cfg_hold), .loc_want(loc_want), .loc_busy(loc_busy),
    .loc_lock(loc_lock), .loc_grant(loc_grant), .bp_req_in(bp_req_in),
    .bp_busy_in(bp_busy_in), .bp_req_out(bp_req_out), .bp_ack_out(bp_ack_out)
  );

  // bench reference: restates the requirements cycle by cycle
  logic [1:0] m_s1, m_s2, m_ack;
  logic       m_b1, m_b2, m_lreq;

  function automatic logic [1:0] exp_req_out(input logic lreq, input logic lvl);
    return lreq ? (lvl ? 2'b10 : 2'b01) : 2'b00;
  endfunction

  function automatic logic [1:0] next_ack(input logic [1:0] cur, input logic [1:0] reqs,
                                          input logic busy);
    if (cur != 2'b00) begin
      if (((reqs & cur) == 2'b00) && !busy) return 2'b00;
      return cur;
    end
    if (reqs[1]) return 2'b10;
    if (reqs[0]) return 2'b01;
    return 2'b00;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_b1 <= 1'b0; m_b2 <= 1'b0;
      m_lreq <= 1'b0; m_ack <= '0;
    end else begin
      m_s1 <= bp_req_in; m_s2 <= m_s1;
      m_b1 <= bp_busy_in; m_b2 <= m_b1;
      m_lreq <= loc_want || loc_lock || (m_lreq && loc_busy) ||
                (cfg_park && m_s2 == 2'b00) || (cfg_hold && m_lreq && m_s2 == 2'b00);
      m_ack <= next_ack(m_ack, m_s2 | exp_req_out(m_lreq, cfg_level), loc_busy | m_b2);
    end
  end

  task automatic chk(input logic [1:0] got, input logic [1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl, input logic park, input logic hold);
    rst_n = 1'b0;
    cfg_level = lvl; cfg_park = park; cfg_hold = hold;
    loc_want = 0; loc_busy = 0; loc_lock = 0; bp_req_in = 0; bp_busy_in = 0;
    step(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b5e));
    @(negedge clk);
    do_reset(1'b1, 1'b0, 1'b0);
    // R1 reset state
    chk(bp_ack_out, 2'b00, "R1 ack after reset");
    chk(bp_req_out, 2'b00, "R1 req after reset");
    chk({1'b0, loc_grant}, 2'b00, "R1 grant after reset");

    // local request on level 1
    loc_want = 1; step(1);
    chk(bp_req_out, 2'b10, "R2 request on selected level");
    chk({1'b0, loc_grant}, 2'b00, "R3 no grant before ack");
    step(1);
    chk(bp_ack_out, 2'b10, "R3 ack level 1");
    chk({1'b0, loc_grant}, 2'b01, "R3 grant with ack");
    loc_want = 0; loc_busy = 1; step(3);
    chk({1'b0, loc_grant}, 2'b01, "R5 held while busy");
    loc_busy = 0; step(1);
    chk(bp_req_out, 2'b00, "R9 request dropped when idle");
    chk(bp_ack_out, 2'b10, "R5 ack lags request by one edge");
    step(1);
    chk(bp_ack_out, 2'b00, "R5 ack released");

    // two remote requests, synchroniser delay and priority
    bp_req_in = 2'b11; step(2);
    chk(bp_ack_out, 2'b00, "R11 not acked before synchroniser");
    step(1);
    chk(bp_ack_out, 2'b10, "R4 level 1 wins");
    bp_req_in = 2'b01; step(3);
    chk(bp_ack_out, 2'b00, "R6 idle gap on handover");
    step(1);
    chk(bp_ack_out, 2'b01, "R6 level 0 after gap");
    bp_req_in = 2'b00; step(3);
    chk(bp_ack_out, 2'b00, "R5 remote release");

    // default master parking
    do_reset(1'b0, 1'b1, 1'b0);
    step(2);
    chk({1'b0, loc_grant}, 2'b01, "R7 parked grant");
    bp_req_in = 2'b10; step(3);
    chk(bp_req_out, 2'b00, "R7 park request withdrawn");
    step(1);
    chk(bp_ack_out, 2'b00, "R6 gap after park");
    step(1);
    chk(bp_ack_out, 2'b10, "R7 remote gets bus");
    bp_req_in = 2'b00; step(4);
    chk({1'b0, loc_grant}, 2'b01, "R7 parked again");

    // hold until asked, then lock
    do_reset(1'b1, 1'b0, 1'b1);
    loc_want = 1; step(2);
    chk({1'b0, loc_grant}, 2'b01, "R8 grant");
    loc_want = 0; step(5);
    chk(bp_req_out, 2'b10, "R8 request kept");
    chk({1'b0, loc_grant}, 2'b01, "R8 grant kept");
    bp_req_in = 2'b01; step(3);
    chk(bp_req_out, 2'b00, "R8 yield on remote request");
    step(2);
    chk(bp_ack_out, 2'b01, "R8 remote owns");
    bp_req_in = 2'b00; step(3);
    chk(bp_ack_out, 2'b00, "R5 remote released");
    loc_want = 1; loc_lock = 1; step(2);
    chk({1'b0, loc_grant}, 2'b01, "R10 locked grant");
    loc_want = 0; bp_req_in = 2'b01; step(6);
    chk({1'b0, loc_grant}, 2'b01, "R10 lock holds against request");
    chk(bp_ack_out, 2'b10, "R10 ack unchanged under lock");
    loc_lock = 0; step(1);
    chk(bp_req_out, 2'b00, "R8 yield after unlock");
    step(1);
    chk(bp_ack_out, 2'b00, "R6 gap after unlock");
    step(1);
    chk(bp_ack_out, 2'b01, "R4 remote granted after unlock");
    bp_req_in = 2'b00; step(4);

    // constrained random against the bench reference
    for (int blk = 0; blk < 6; blk++) begin
      do_reset(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      for (int cyc = 0; cyc < 500; cyc++) begin
        chk(bp_ack_out, m_ack, "R4 R5 R6 random ack");
        chk(bp_req_out, exp_req_out(m_lreq, cfg_level), "R2 R7 R8 R9 random req");
        chk({1'b0, loc_grant}, {1'b0, m_lreq & m_ack[cfg_level]}, "R3 R10 random grant");
        loc_want = (($urandom % 8) < 3);
        loc_busy = (($urandom % 8) < 2);
        loc_lock = (($urandom % 16) == 0);
        if (($urandom % 8) == 0) bp_req_in = 2'($urandom % 4);
        bp_busy_in = (($urandom % 8) == 0);
        step(1);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule